// File: doc/BRIEF.md
# Character-Cell Rectangle Engine

This engine works on a text buffer in which every cell is two bytes: a character code at the cell address and a colour attribute at the next byte. It takes one command at a time and carries it out through a single memory port. It moves a rectangle of cells from one place to another, even when the two rectangles overlap. It can paint one character and attribute over a rectangle. It can also write a stream of character codes into a rectangle, in row-major order.

Cell addresses come from a column stride and a row stride. The column stride is a power of two chosen by a small shift field. The row stride follows from the virtual screen width in pixels, at eight pixels per cell. The memory port carries one access at a time, either a byte or a halfword. An access stays on the port until the port answers with ready. The engine pulses done when a command has finished.

Top module: `cellblit_engine`

## Requirements
- R1: Column stride is (2 << stride_sh) bytes. Row stride is the column stride times (virt_w / 8), with the division truncated. Cell (x, y) sits at byte offset x*column + y*row, modulo 2^AW.
- R2: A copy (cmd_op = 2'b01) runs forward, from top-left to bottom-right in row-major order, in two cases: when src_y > dst_y, or when the rows are equal and src_x > dst_x.
- R3: Every other copy runs backward. It starts at cell (x+w-1, y+h-1) of both rectangles and steps by the negated column and row strides. This includes src equal to dst.
- R4: A copy handles each cell with a halfword read (mem_size = 1, mem_we = 0) at the source cell, then a halfword write of the data it read to the destination cell. The final buffer equals a copy taken from the contents before the command, even when the rectangles overlap.
- R5: The attribute byte is {bg_idx[3:0], fg_idx[3:0]}. The upper four bits of bg_idx and of fg_idx are ignored.
- R6: A fill (cmd_op = 2'b10) covers the destination rectangle in row-major order. For each cell it writes fill_char as a byte (mem_size = 0, data in mem_wdata[7:0]) at the cell address, then the attribute byte at the cell address + 1.
- R7: A blit (cmd_op = 2'b11) writes cells the same way as a fill, but the character is idx_data, sampled in the cycle where idx_take is raised, one index per cell. It stops after blit_len cells, even in the middle of a row. If blit_len is 0, it ends with no access.
- R8: A command with rect_w = 0 or rect_h = 0 raises done one cycle after it is accepted and makes no memory access.
- R9: A command is accepted only while the engine is idle with cmd_valid high and cmd_op not 2'b00. Commands offered while busy, and op 2'b00, have no effect. busy is high from the cycle after acceptance until done.
- R10: Once raised, mem_req, mem_addr, mem_we and mem_wdata hold steady until a cycle with mem_ready high. done pulses for one cycle, in the cycle after the final access completes, with busy and mem_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 01 copy, 10 fill, 11 blit, 00 none |
| src_x | input | CW | Copy source column |
| src_y | input | CW | Copy source row |
| dst_x | input | CW | Destination column |
| dst_y | input | CW | Destination row |
| rect_w | input | CW | Rectangle width in cells |
| rect_h | input | CW | Rectangle height in cells |
| virt_w | input | VW | Virtual screen width in pixels |
| stride_sh | input | SHW | Column stride shift |
| fill_char | input | 8 | Character used by fill |
| fg_idx | input | 8 | Foreground index (low 4 bits used) |
| bg_idx | input | 8 | Background index (low 4 bits used) |
| blit_len | input | LW | Number of indices for blit |
| idx_data | input | 8 | Current blit index |
| idx_take | output | 1 | Pulse: idx_data was consumed |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 1 | 0 byte, 1 halfword |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
Copies are run in four overlap arrangements: source row below, same row with source to the right, same row with source to the left, and destination below. An identical source and destination is run as well. Each copy is compared both access by access and against a copy taken from a snapshot, so a wrong direction shows up as corrupted cells and a wrong start corner shows up as a bad address. Fills use a wide stride shift and attribute inputs with their upper bits set, which separates stride arithmetic from nibble packing. Blits with a short, an excess and a zero length, plus empty rectangles, op 2'b00, a command offered mid-run and stalling ready patterns, cover the edges of termination and of the handshake.

// File: rtl/cellblit_pkg.sv
package cellblit_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_COPY = 2'b01,
    OP_FILL = 2'b10,
    OP_BLIT = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WCH,
    ST_WAT
  } st_e;
endpackage

// File: rtl/cellblit_attr.sv
module cellblit_attr (
  input  logic [7:0] fg,
  input  logic [7:0] bg,
  output logic [7:0] attr
);
  assign attr = {bg[3:0], fg[3:0]};
endmodule

// File: rtl/cellblit_geom.sv
module cellblit_geom #(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int VW  = 16,
  parameter int SHW = 2
) (
  input  logic           is_copy,
  input  logic [CW-1:0]  sx,
  input  logic [CW-1:0]  sy,
  input  logic [CW-1:0]  dx,
  input  logic [CW-1:0]  dy,
  input  logic [CW-1:0]  w,
  input  logic [CW-1:0]  h,
  input  logic [VW-1:0]  vw,
  input  logic [SHW-1:0] sh,
  output logic [AW-1:0]  s_base,
  output logic [AW-1:0]  d_base,
  output logic [AW-1:0]  cs,
  output logic [AW-1:0]  rs
);
  logic [AW-1:0] col_b, row_b, cells;
  logic [AW-1:0] sxo, syo, dxo, dyo;
  logic          fwd;

  always_comb begin
    col_b = AW'(2) << sh;
    cells = AW'(vw >> 3);
    row_b = col_b * cells;
    // fill and blit always walk forward; copy picks by overlap order
    fwd = !is_copy || (sy > dy) || ((sy == dy) && (sx > dx));
    if (fwd) begin
      sxo = AW'(sx);
      syo = AW'(sy);
      dxo = AW'(dx);
      dyo = AW'(dy);
    end else begin
      sxo = AW'(sx) + AW'(w) - AW'(1);
      syo = AW'(sy) + AW'(h) - AW'(1);
      dxo = AW'(dx) + AW'(w) - AW'(1);
      dyo = AW'(dy) + AW'(h) - AW'(1);
    end
    s_base = sxo * col_b + syo * row_b;
    d_base = dxo * col_b + dyo * row_b;
    cs     = fwd ? col_b : (AW'(0) - col_b);
    rs     = fwd ? row_b : (AW'(0) - row_b);
  end
endmodule

// File: rtl/cellblit_walker.sv
module cellblit_walker #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_s,
  input  logic [AW-1:0] ld_d,
  input  logic [AW-1:0] ld_cs,
  input  logic [AW-1:0] ld_rs,
  input  logic [CW-1:0] ld_w,
  input  logic [CW-1:0] ld_h,
  output logic [AW-1:0] cur_s,
  output logic [AW-1:0] cur_d,
  output logic [AW-1:0] nxt_s,
  output logic [AW-1:0] nxt_d,
  output logic          last
);
  logic [CW-1:0] col, row, w_m1, h_m1;
  logic [AW-1:0] s_ptr, d_ptr, s_row, d_row, cs, rs;
  logic          end_col;

  assign end_col = (col == w_m1);
  assign last    = end_col && (row == h_m1);
  assign cur_s   = s_ptr;
  assign cur_d   = d_ptr;
  assign nxt_s   = end_col ? (s_row + rs) : (s_ptr + cs);
  assign nxt_d   = end_col ? (d_row + rs) : (d_ptr + cs);

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0; row <= '0; w_m1 <= '0; h_m1 <= '0;
      s_ptr <= '0; d_ptr <= '0; s_row <= '0; d_row <= '0;
      cs <= '0; rs <= '0;
    end else if (load) begin
      col <= '0; row <= '0;
      w_m1 <= ld_w - 1'b1;
      h_m1 <= ld_h - 1'b1;
      s_ptr <= ld_s; s_row <= ld_s;
      d_ptr <= ld_d; d_row <= ld_d;
      cs <= ld_cs; rs <= ld_rs;
    end else if (step) begin
      s_ptr <= nxt_s;
      d_ptr <= nxt_d;
      if (end_col) begin
        col   <= '0;
        row   <= row + 1'b1;
        s_row <= s_row + rs;
        d_row <= d_row + rs;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R3: the walk never leaves the rectangle
  p_walk_bound_r3: assert property (@(posedge clk) disable iff (rst)
    step |-> (col <= w_m1) && (row <= h_m1));
endmodule

// File: rtl/cellblit_engine.sv
module cellblit_engine
  import cellblit_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int VW  = 16,
  parameter int SHW = 2,
  parameter int LW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [CW-1:0]  src_x,
  input  logic [CW-1:0]  src_y,
  input  logic [CW-1:0]  dst_x,
  input  logic [CW-1:0]  dst_y,
  input  logic [CW-1:0]  rect_w,
  input  logic [CW-1:0]  rect_h,
  input  logic [VW-1:0]  virt_w,
  input  logic [SHW-1:0] stride_sh,
  input  logic [7:0]     fill_char,
  input  logic [7:0]     fg_idx,
  input  logic [7:0]     bg_idx,
  input  logic [LW-1:0]  blit_len,
  input  logic [7:0]     idx_data,
  output logic           idx_take,
  output logic           busy,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic           mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata,
  input  logic           mem_ready
);
  localparam int CELLW = 16;

  st_e           st;
  op_e           op_q;
  logic [7:0]    chr_q, attr_q, attr_w;
  logic [LW-1:0] len_q, cnt;
  logic [AW-1:0] s_base, d_base, cs, rs;
  logic [AW-1:0] cur_s, cur_d, nxt_s, nxt_d;
  logic          last, accept, hs, empty, stop_cell, step;
  op_e           op_in;

  assign op_in     = op_e'(cmd_op);
  assign accept    = (st == ST_IDLE) && cmd_valid && (op_in != OP_NONE);
  assign hs        = mem_req && mem_ready;
  assign empty     = (rect_w == '0) || (rect_h == '0) ||
                     ((op_in == OP_BLIT) && (blit_len == '0));
  assign stop_cell = last || ((op_q == OP_BLIT) && (cnt == len_q));
  assign step      = hs && (((st == ST_WR) && !last) ||
                            ((st == ST_WAT) && !stop_cell));

  cellblit_attr u_attr (.fg(fg_idx), .bg(bg_idx), .attr(attr_w));

  cellblit_geom #(.AW(AW), .CW(CW), .VW(VW), .SHW(SHW)) u_geom (
    .is_copy(op_in == OP_COPY),
    .sx(src_x), .sy(src_y), .dx(dst_x), .dy(dst_y),
    .w(rect_w), .h(rect_h), .vw(virt_w), .sh(stride_sh),
    .s_base(s_base), .d_base(d_base), .cs(cs), .rs(rs)
  );

  cellblit_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .ld_s(s_base), .ld_d(d_base), .ld_cs(cs), .ld_rs(rs),
    .ld_w(rect_w), .ld_h(rect_h),
    .cur_s(cur_s), .cur_d(cur_d), .nxt_s(nxt_s), .nxt_d(nxt_d),
    .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; op_q <= OP_NONE;
      chr_q <= '0; attr_q <= '0; len_q <= '0; cnt <= '0;
      busy <= 1'b0; done <= 1'b0; idx_take <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_size <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0;
    end else begin
      done     <= 1'b0;
      idx_take <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          op_q   <= op_in;
          chr_q  <= fill_char;
          attr_q <= attr_w;
          len_q  <= blit_len;
          cnt    <= LW'(1);
          if (empty) begin
            done <= 1'b1;
          end else begin
            busy    <= 1'b1;
            mem_req <= 1'b1;
            if (op_in == OP_COPY) begin
              mem_we   <= 1'b0;
              mem_size <= 1'b1;
              mem_addr <= s_base;
              st       <= ST_RD;
            end else begin
              mem_we    <= 1'b1;
              mem_size  <= 1'b0;
              mem_addr  <= d_base;
              mem_wdata <= {8'h00, (op_in == OP_BLIT) ? idx_data : fill_char};
              idx_take  <= (op_in == OP_BLIT);
              st        <= ST_WCH;
            end
          end
        end
        ST_RD: if (hs) begin
          mem_wdata <= mem_rdata[CELLW-1:0];
          mem_we    <= 1'b1;
          mem_addr  <= cur_d;
          st        <= ST_WR;
        end
        ST_WR: if (hs) begin
          if (last) begin
            mem_req <= 1'b0; mem_we <= 1'b0; busy <= 1'b0; done <= 1'b1;
            st <= ST_IDLE;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= nxt_s;
            st       <= ST_RD;
          end
        end
        ST_WCH: if (hs) begin
          mem_addr  <= cur_d + AW'(1);
          mem_wdata <= {8'h00, attr_q};
          st        <= ST_WAT;
        end
        ST_WAT: if (hs) begin
          if (stop_cell) begin
            mem_req <= 1'b0; mem_we <= 1'b0; busy <= 1'b0; done <= 1'b1;
            st <= ST_IDLE;
          end else begin
            mem_addr  <= nxt_d;
            mem_wdata <= {8'h00, (op_q == OP_BLIT) ? idx_data : chr_q};
            idx_take  <= (op_q == OP_BLIT);
            cnt       <= cnt + 1'b1;
            st        <= ST_WCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: a stalled access is held unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));
  // R9: no memory traffic outside a busy command
  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R8: the completion cycle is quiet
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req && !busy);
  // R4: reads are always whole cells
  p_rd_half_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> mem_size);
  // R6: attribute byte follows the character byte
  p_attr_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAT && $past(st) == ST_WCH) |->
      mem_addr == $past(mem_addr) + AW'(1));
endmodule

// File: tb/cellblit_engine_test.sv
module cellblit_engine_test;
  localparam int AW = 16, CW = 8, VW = 16, SHW = 2, LW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [CW-1:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
  logic [CW-1:0] rect_w = '0, rect_h = '0;
  logic [VW-1:0] virt_w = '0;
  logic [SHW-1:0] stride_sh = '0;
  logic [7:0] fill_char = '0, fg_idx = '0, bg_idx = '0, idx_data = '0;
  logic [LW-1:0] blit_len = '0;
  logic idx_take, busy, done, mem_req, mem_we, mem_size;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  always #10 clk = ~clk;

  cellblit_engine #(.AW(AW), .CW(CW), .VW(VW), .SHW(SHW), .LW(LW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
    .rect_w(rect_w), .rect_h(rect_h), .virt_w(virt_w), .stride_sh(stride_sh),
    .fill_char(fill_char), .fg_idx(fg_idx), .bg_idx(bg_idx),
    .blit_len(blit_len), .idx_data(idx_data), .idx_take(idx_take),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [7:0] mem  [0:65535];
  logic [7:0] snap [0:65535];
  logic [7:0] emem [0:65535];
  int q_we[$], q_sz[$], q_ad[$], q_dt[$];
  int errors = 0, checks = 0, cyc = 0;

  function automatic logic [7:0] idx_of(int k);
    return 8'(8'h80 + k * 3);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic push(int we, int sz, int ad, int dt);
    q_we.push_back(we); q_sz.push_back(sz);
    q_ad.push_back(ad & 16'hFFFF); q_dt.push_back(dt);
  endtask

  // reference model: expected accesses and final buffer
  task automatic build(int op, int sx, int sy, int dx, int dy, int w, int h,
                       int vw, int sh, int ch, int fg, int bg, int len);
    int cs, rs, attr, n;
    bit fwd;
    cs = 2 << sh;
    rs = cs * (vw / 8);
    attr = ((bg & 15) << 4) | (fg & 15);
    for (int i = 0; i < 65536; i++) begin snap[i] = mem[i]; emem[i] = mem[i]; end
    if (w == 0 || h == 0) return;
    if (op == 1) begin
      fwd = (sy > dy) || (sy == dy && sx > dx);
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          int cc, rr, sa, da;
          cc = fwd ? c : (w - 1 - c);
          rr = fwd ? r : (h - 1 - r);
          sa = ((sx + cc) * cs + (sy + rr) * rs) & 16'hFFFF;
          da = ((dx + cc) * cs + (dy + rr) * rs) & 16'hFFFF;
          push(0, 1, sa, 0);
          push(1, 1, da, -1);
          emem[da] = snap[sa];
          emem[(da + 1) & 16'hFFFF] = snap[(sa + 1) & 16'hFFFF];
        end
    end else if (op == 2 || op == 3) begin
      n = 0;
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          int da, cv;
          if (op == 3 && n >= len) continue;
          da = ((dx + c) * cs + (dy + r) * rs) & 16'hFFFF;
          cv = (op == 3) ? int'(idx_of(n)) : (ch & 255);
          push(1, 0, da, cv);
          push(1, 0, da + 1, attr);
          emem[da] = 8'(cv);
          emem[(da + 1) & 16'hFFFF] = 8'(attr);
          n++;
        end
    end
  endtask

  task automatic run(string tag, int op, int sx, int sy, int dx, int dy,
                     int w, int h, int vw, int sh, int ch, int fg, int bg,
                     int len, int rmode, bit inject);
    int iter, since_hs, last_rd, ptr, bad, accesses;
    bit seen_done, busy_bad;
    build(op, sx, sy, dx, dy, w, h, vw, sh, ch, fg, bg, len);
    accesses = q_we.size();
    ptr = 0; idx_data = idx_of(0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op);
    src_x = CW'(sx); src_y = CW'(sy); dst_x = CW'(dx); dst_y = CW'(dy);
    rect_w = CW'(w); rect_h = CW'(h); virt_w = VW'(vw); stride_sh = SHW'(sh);
    fill_char = 8'(ch); fg_idx = 8'(fg); bg_idx = 8'(bg); blit_len = LW'(len);
    iter = 0; since_hs = 100; last_rd = 0; seen_done = 0; busy_bad = 0;
    while (!seen_done && iter < 20000) begin
      @(negedge clk);
      iter++; cyc++; since_hs++;
      cmd_valid = 1'b0;
      if (inject && iter == 3) begin
        // R9: offered while busy, must be ignored
        cmd_valid = 1'b1; cmd_op = 2'b01;
        src_x = 8'd0; src_y = 8'd0; dst_x = 8'd1; dst_y = 8'd1;
        rect_w = 8'd2; rect_h = 8'd2; fill_char = 8'h00; fg_idx = 8'h00;
      end
      if (idx_take) begin ptr++; idx_data = idx_of(ptr); end
      case (rmode)
        0: mem_ready = 1'b1;
        1: mem_ready = (cyc % 3) != 1;
        default: mem_ready = (cyc % 4) == 0;
      endcase
      if (done) begin
        seen_done = 1;
        if (accesses == 0)
          check(iter == 1, tag, "empty done latency", iter, 1);
        else
          check(since_hs == 1, "R10", "done latency", since_hs, 1);
        check(q_we.size() == 0, tag, "accesses left", q_we.size(), 0);
      end else if (!busy && !busy_bad) begin
        busy_bad = 1;
        check(0, "R9", "busy during command", 0, 1);
      end
      if (!seen_done && mem_req && mem_ready) begin
        since_hs = 0;
        if (q_we.size() == 0) begin
          check(0, tag, "unexpected access addr", int'(mem_addr), -1);
        end else begin
          int ewe, esz, ead, edt, act;
          ewe = q_we.pop_front(); esz = q_sz.pop_front();
          ead = q_ad.pop_front(); edt = q_dt.pop_front();
          check(int'(mem_we) == ewe && int'(mem_size) == esz,
                tag, "we/size", {mem_we, mem_size}, (ewe << 1) | esz);
          check(int'(mem_addr) == ead, tag, "address", int'(mem_addr), ead);
          if (mem_we) begin
            if (esz == 1) begin
              check(int'(mem_wdata) == last_rd, "R4", "copy data",
                    int'(mem_wdata), last_rd);
            end else begin
              act = int'(mem_wdata[7:0]);
              check(act == edt, tag, "byte data", act, edt);
            end
          end
        end
        if (mem_we) begin
          mem[mem_addr] = mem_wdata[7:0];
          if (mem_size) mem[AW'(mem_addr + 1)] = mem_wdata[15:8];
        end else begin
          mem_rdata = {mem[AW'(mem_addr + 1)], mem[mem_addr]};
          last_rd = int'(mem_rdata);
        end
      end
    end
    check(seen_done, tag, "done seen", int'(seen_done), 1);
    bad = 0;
    for (int i = 0; i < 65536; i++) if (mem[i] !== emem[i]) bad++;
    check(bad == 0, tag, "buffer mismatches", bad, 0);
    q_we.delete(); q_sz.delete(); q_ad.delete(); q_dt.delete();
    mem_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req && !idx_take, "R9", "reset state",
          {busy, done, mem_req, idx_take}, 0);

    // R5 R6 R1: fill with upper nibble garbage on the indices
    run("R6", 2, 0, 0, 3, 2, 4, 3, 80, 0, 8'h41, 8'hF5, 8'h3A, 0, 0, 0);
    // R1: widest stride shift, other width, stalling port
    run("R1", 2, 0, 0, 2, 1, 3, 2, 64, 3, 8'h5A, 8'h07, 8'hC2, 0, 1, 0);
    // R2: source row below
    run("R2", 1, 2, 5, 4, 3, 5, 3, 80, 0, 0, 0, 0, 0, 0, 0);
    // R2: same row, source right
    run("R2", 1, 3, 4, 1, 4, 6, 2, 80, 0, 0, 0, 0, 0, 1, 0);
    // R3: destination below, overlapping
    run("R3", 1, 1, 1, 2, 2, 4, 3, 80, 0, 0, 0, 0, 0, 0, 0);
    // R3: same row, source left
    run("R3", 1, 0, 6, 2, 6, 5, 1, 80, 1, 0, 0, 0, 0, 2, 0);
    // R3: identical rectangles
    run("R3", 1, 4, 4, 4, 4, 2, 2, 80, 0, 0, 0, 0, 0, 0, 0);
    // R7: short list stops mid-row
    run("R7", 3, 0, 0, 5, 7, 3, 3, 80, 0, 0, 8'h02, 8'h01, 5, 1, 0);
    // R7: longer list than rectangle
    run("R7", 3, 0, 0, 1, 9, 3, 3, 80, 0, 0, 8'h1E, 8'h2D, 20, 0, 0);
    // R7: zero length
    run("R7", 3, 0, 0, 1, 9, 3, 3, 80, 0, 0, 8'h01, 8'h01, 0, 0, 0);
    // R8: zero width fill, zero height copy
    run("R8", 2, 0, 0, 1, 1, 0, 4, 80, 0, 8'h33, 1, 1, 0, 0, 0);
    run("R8", 1, 0, 3, 1, 1, 3, 0, 80, 0, 0, 0, 0, 0, 0, 0);
    // R9: command offered while busy
    run("R9", 2, 0, 0, 6, 12, 3, 2, 80, 0, 8'h77, 8'h04, 8'h08, 0, 2, 1);
    // R10: copy under heavy stalls
    run("R10", 1, 0, 14, 3, 13, 4, 2, 80, 0, 0, 0, 0, 0, 2, 0);

    // R9: op 00 is not a command
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; rect_w = 8'd2; rect_h = 8'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      bit any;
      any = 0;
      for (int k = 0; k < 5; k++) begin
        if (busy || mem_req || done) any = 1;
        @(negedge clk);
      end
      check(!any, "R9", "op 00 activity", int'(any), 0);
    end

    summary();
    $finish;
  end
endmodule